// File: doc/BRIEF.md
# Serial Final Modular Reduction Unit

This block performs the last correction step of a Montgomery exponentiation. The exponentiation leaves a result P that may lie anywhere in [0, 2N). This unit returns P mod N. It subtracts the modulus N from P one S-bit word per clock, least significant word first, and carries the borrow from each word to the next. The borrow left after the top word gives the sign of P − N. That sign then picks either the stored difference or the untouched P, and the chosen value is streamed out word by word with a valid flag.

The host loads both operands one word at a time, through a word address and an operand select, while the unit is idle. It then pulses `start`. Each operand occupies M = ceil((K+2)/S) words. Word 0 holds the least significant bits, and unused high bits are zero. The difference words go to a separate scratch store, so the operands held in the unit are never overwritten. The same operation can therefore be repeated without a reload.

Top module: `serial_mod_reduce`

## Requirements
- R1: After reset, `out_valid` and `busy` are low.
- R2: When P < N, including P = N−1 and P = 0, the streamed words equal the words of P.
- R3: When P ≥ N, including P = N (result 0), the streamed words equal the words of P − N.
- R4: Inputs up to 2N−1 are reduced correctly; P = 2N−1 yields N−1.
- R5: When `start` is sampled high while `busy` is low, `out_valid` first reads high after the (M+2)-th following clock edge. That is M subtraction cycles, one decision cycle and one output register. The last word therefore appears M+1 cycles after the subtraction ends.
- R6: `out_valid` is high for exactly M consecutive cycles per operation, carrying word 0 first and word M−1 last.
- R7: A `start` pulse while `busy` is high is ignored: no extra operation and no extra output words follow.
- R8: Operand writes while `busy` is high are ignored: the current and all later results use the previously stored operand.
- R9: `busy` rises on the edge after an accepted `start` and falls on the same edge as `out_valid` falls.
- R10: The stored operands survive an operation, so a second `start` with no reload produces the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Operand word write strobe (accepted only while idle) |
| wr_sel | input | 1 | Operand select: 0 writes P, 1 writes N |
| wr_addr | input | AW | Word index, 0 = least significant |
| wr_data | input | S | Operand word |
| start | input | 1 | Begin one reduction (accepted only while idle) |
| busy | output | 1 | Operation in progress, including output streaming |
| out_valid | output | 1 | `out_data` carries a result word |
| out_data | output | S | Result word, least significant first |

## Verification
On every cycle, the assertions check the control timing. They check that `out_valid` rises exactly M+2 edges after an accepted start and that each valid burst lasts exactly M cycles. They also check that `busy` only rises after a start and falls together with `out_valid`. The assertions cannot see the arithmetic result or the effect of ignored writes. Those are shown only by the bench's scenarios, which compare each streamed word with an independent model at the boundaries P = N−1, N and 2N−1, and which repeat an operation after a disturbed run.

// File: rtl/csub_pkg.sv
package csub_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SUB,
    ST_SEL,
    ST_OUT
  } csub_state_e;

  function automatic int words_for(input int bits, input int width);
    return (bits + width - 1) / width;
  endfunction
endpackage

// File: rtl/csub_wordmem.sv
module csub_wordmem #(
  parameter int W     = 16,
  parameter int DEPTH = 5,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam logic [AW:0] LIM = (AW+1)'(DEPTH - 1);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && ({1'b0, waddr} <= LIM)) mem[waddr] <= wdata;
  end

  assign rdata = ({1'b0, raddr} <= LIM) ? mem[raddr] : '0;
endmodule

// File: rtl/csub_borrow_stage.sv
module csub_borrow_stage #(
  parameter int W = 16
) (
  input  logic [W-1:0] minuend,
  input  logic [W-1:0] subtrahend,
  input  logic         borrow_in,
  output logic [W-1:0] diff,
  output logic         borrow_out
);
  logic [W:0] wide;

  always_comb begin
    wide       = {1'b0, minuend} - {1'b0, subtrahend} - {{W{1'b0}}, borrow_in};
    diff       = wide[W-1:0];
    borrow_out = wide[W];
  end
endmodule

// File: rtl/serial_mod_reduce.sv
module serial_mod_reduce
  import csub_pkg::*;
#(
  parameter int K  = 64,
  parameter int S  = 16,
  parameter int M  = words_for(K + 2, S),
  parameter int AW = (M > 1) ? $clog2(M) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [AW-1:0] wr_addr,
  input  logic [S-1:0]  wr_data,
  input  logic          start,
  output logic          busy,
  output logic          out_valid,
  output logic [S-1:0]  out_data
);
  localparam logic [AW-1:0] LAST_IDX = AW'(M - 1);

  csub_state_e   state_q;
  logic [AW-1:0] idx_q;
  logic          borrow_q;
  logic          take_diff_q;
  logic          out_valid_q;
  logic [S-1:0]  out_data_q;

  logic [S-1:0]  p_word, n_word, s_word, d_word;
  logic          b_next, b_in;
  logic          host_we, scr_we;

  assign busy    = (state_q != ST_IDLE) || out_valid_q;
  assign host_we = wr_en && !busy;
  assign scr_we  = (state_q == ST_SUB);
  assign b_in    = (idx_q == '0) ? 1'b0 : borrow_q;

  csub_wordmem #(.W(S), .DEPTH(M), .AW(AW)) u_pmem (
    .clk(clk), .we(host_we && !wr_sel), .waddr(wr_addr), .wdata(wr_data),
    .raddr(idx_q), .rdata(p_word)
  );

  csub_wordmem #(.W(S), .DEPTH(M), .AW(AW)) u_nmem (
    .clk(clk), .we(host_we && wr_sel), .waddr(wr_addr), .wdata(wr_data),
    .raddr(idx_q), .rdata(n_word)
  );

  csub_wordmem #(.W(S), .DEPTH(M), .AW(AW)) u_scratch (
    .clk(clk), .we(scr_we), .waddr(idx_q), .wdata(d_word),
    .raddr(idx_q), .rdata(s_word)
  );

  csub_borrow_stage #(.W(S)) u_stage (
    .minuend(p_word), .subtrahend(n_word), .borrow_in(b_in),
    .diff(d_word), .borrow_out(b_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      borrow_q    <= 1'b0;
      take_diff_q <= 1'b0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          out_valid_q <= 1'b0;
          idx_q       <= '0;
          if (start && !out_valid_q) state_q <= ST_SUB;
        end
        ST_SUB: begin
          borrow_q <= b_next;
          if (idx_q == LAST_IDX) begin
            idx_q   <= '0;
            state_q <= ST_SEL;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_SEL: begin
          take_diff_q <= ~borrow_q;
          state_q     <= ST_OUT;
        end
        ST_OUT: begin
          out_data_q  <= take_diff_q ? s_word : p_word;
          out_valid_q <= 1'b1;
          if (idx_q == LAST_IDX) begin
            idx_q   <= '0;
            state_q <= ST_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
endmodule

// File: rtl/serial_mod_reduce_chk.sv
module serial_mod_reduce_chk #(
  parameter int M = 5
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic out_valid
);
  logic [15:0] since_start;
  logic [15:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_start <= '0;
      run_len     <= '0;
    end else begin
      if (start && !busy) since_start <= 16'd1;
      else if (busy)      since_start <= since_start + 16'd1;
      run_len <= out_valid ? run_len + 16'd1 : '0;
    end
  end

  AST_FIRST_WORD_TIMING: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> since_start == 16'(M + 3)); // R5

  AST_BURST_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> run_len == 16'(M)); // R6

  AST_BUSY_ENDS_WITH_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $fell(out_valid)); // R9

  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start)); // R7

  AST_VALID_INSIDE_BUSY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy); // R9
endmodule

bind serial_mod_reduce serial_mod_reduce_chk #(.M(M)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .out_valid(out_valid)
);

// File: tb/sim_serial_mod_reduce.sv
module sim_serial_mod_reduce;
  localparam int K  = 64;
  localparam int S  = 16;
  localparam int M  = (K + 2 + S - 1) / S;
  localparam int AW = (M > 1) ? $clog2(M) : 1;
  localparam int VW = M * S;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, wr_sel = 1'b0, start = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [S-1:0]  wr_data = '0;
  logic          busy, out_valid;
  logic [S-1:0]  out_data;

  int compared = 0;
  int mismatched = 0;
  logic [S-1:0] exp_q[$];
  string        tag_q[$];

  always #5 clk = ~clk;

  serial_mod_reduce #(.K(K), .S(S)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .start(start), .busy(busy), .out_valid(out_valid),
    .out_data(out_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [VW-1:0] act,
                     input logic [VW-1:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a word is presented
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected word", VW'(out_data), '0);
      end else begin
        logic [S-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(out_data == e, t, VW'(out_data), VW'(e));
      end
    end
  end

  task automatic write_word(input bit sel, input int a, input logic [S-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input logic [VW-1:0] p, input logic [VW-1:0] n);
    for (int k = 0; k < M; k++) begin
      write_word(1'b0, k, p[k*S +: S]);
      write_word(1'b1, k, n[k*S +: S]);
    end
  endtask

  task automatic run_op(input logic [VW-1:0] p, input logic [VW-1:0] n,
                        input string tag, input bit dist_start, input bit dist_wr);
    logic [VW-1:0] r;
    int lat;
    int run;
    r = (p >= n) ? p - n : p;
    for (int k = 0; k < M; k++) begin
      exp_q.push_back(r[k*S +: S]);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!out_valid && lat < 4 * M + 10) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      start = (lat == 2) && dist_start;
      wr_en = (lat == 2) && dist_wr;
      wr_sel = 1'b0; wr_addr = '0; wr_data = 16'hDEAD;
    end
    start = 1'b0; wr_en = 1'b0;
    chk(lat == M + 2, "R5 first word latency", VW'(lat), VW'(M + 2));
    run = 0;
    while (out_valid && run < 4 * M) begin
      run++;
      @(posedge clk);
      @(negedge clk);
    end
    chk(run == M, "R6 valid burst length", VW'(run), VW'(M));
    chk(busy == 1'b0, "R9 busy clears with last word", VW'(busy), '0);
  endtask

  task automatic finish_up;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin
    logic [VW-1:0] n1, n2, p;
    n1 = VW'(64'hC5A3_1F09_7E44_D2B1);
    n2 = VW'(64'h8000_0000_0000_0001);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", VW'(out_valid), '0);
    chk(busy == 1'b0, "R1 busy after reset", VW'(busy), '0);
    rst = 1'b0;

    p = n1 - 1; load(p, n1); run_op(p, n1, "R2 P=N-1", 0, 0);
    p = '0;     load(p, n1); run_op(p, n1, "R2 P=0", 0, 0);
    p = n1;     load(p, n1); run_op(p, n1, "R3 P=N", 0, 0);
    p = n1 + 5; load(p, n1); run_op(p, n1, "R3 P=N+5", 0, 0);
    p = 2 * n1 - 1; load(p, n1); run_op(p, n1, "R4 P=2N-1", 0, 0);
    p = 2 * n2 - 1; load(p, n2); run_op(p, n2, "R4 P=2N-1 sparse N", 0, 0);
    // R10: rerun with no reload after a subtracting case
    run_op(p, n2, "R10 repeat without reload", 0, 0);

    // R7: extra start during operation must not trigger a second run
    p = n1 + 77; load(p, n1); run_op(p, n1, "R7 start while busy", 1, 0);
    repeat (3 * M + 6) begin
      @(negedge clk);
      if (out_valid || busy) chk(1'b0, "R7 no second operation", VW'(busy), '0);
    end
    chk(exp_q.size() == 0, "R7 scoreboard drained", VW'(exp_q.size()), '0);

    // R8: operand write during operation is dropped, now and afterwards
    p = n1 + 64'h1234_5678; load(p, n1); run_op(p, n1, "R8 write while busy", 0, 1);
    run_op(p, n1, "R8 rerun after dropped write", 0, 0);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all words delivered", VW'(exp_q.size()), '0);
    finish_up();
  end
endmodule